// File: doc/BRIEF.md
# Multi-node stoppable clock enable

This block produces the local clock for one synchronous block that hosts several token ring nodes. The local clock is not a real gated clock: it is a one-cycle enable tick derived from a free-running reference clock by a programmable divider. Every tick stands for one local clock edge. Nodes and the rest of the synchronous block advance only on ticks.

Each node raises a request while it wants the local clock to keep running. A node drops its request when its recycle count has run out and its token has not yet come back. The block runs the divider only while every node's request is satisfied. If any one node is waiting, the whole block stops, even if other nodes are holding a token or are still recycling. The stop falls on a period boundary, so no shortened period is ever issued.

A token-arrival pulse from the ring releases the waiting node without any local tick. The block remembers that release until the node's own request comes back. The stopped state clears on the next reference edge, and the first tick after a restart is one full programmed period later. The divide ratio may only be changed while the block is stopped, and each new value is picked up when the divider next reloads.

Top module: `stoppable_clk_en`

## Requirements
- R1: While running, `tick` pulses once every DIV+1 reference cycles, where DIV is the programmed unsigned ratio; DIV = 0 gives a tick on every cycle.
- R2: `tick` can only be high in a cycle where every node is satisfied. A node is satisfied when its `node_req` bit is high, when its `tok_arrive` bit is high, or when it has a recorded pending release.
- R3: In any cycle where some node is unsatisfied, `tick` is low and `stopped` is high. The divider then restarts from a full period, so no partial period is issued.
- R4: A single unsatisfied node stops the block while every other node keeps its request high. With two waiting nodes, a token for only one of them leaves the block stopped.
- R5: A `tok_arrive` pulse for a node whose `node_req` is low records a release that keeps the node satisfied until its `node_req` goes high. A pulse for a node whose `node_req` is already high has no effect.
- R6: After a stop, the first tick comes DIV+1 cycles after the first cycle in which all nodes are satisfied again. `stopped` is still high in that first cycle and low from the next one.
- R7: A ratio write (`div_wr` high) is accepted only in a cycle where `stopped` is high. A write while running is ignored, and the tick spacing does not change.
- R8: A ratio accepted while stopped sets the spacing of the ticks after the restart.
- R9: Under reset, `tick` is low, `stopped` is high and the ratio takes the parameter DIV_RST. After release, the first tick comes DIV_RST+2 cycles after the first edge outside reset, provided all nodes request.
- R10: `stopped` is high exactly in the cycles where ticks are held back by a stop. These are the cycle in which a node first becomes unsatisfied, every cycle after it, and the first cycle in which all are satisfied again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_req | input | NODES | Per-node clock-enable request |
| tok_arrive | input | NODES | Per-node token-arrival pulse |
| div_wr | input | 1 | Ratio write strobe |
| div_val | input | DIV_W | Ratio value to write |
| tick | output | 1 | Local clock enable tick |
| stopped | output | 1 | High while ticks are held back by a stop |

## Verification
The bench builds the block with NODES = 3, DIV_W = 4 and DIV_RST = 2. With these values a full period is at most sixteen reference cycles. The divide-by-one case, the largest ratio and the boundary between write and restart therefore all occur many times in a short run. Three nodes are enough to show one late node stopping others that are still requesting. They are also enough for two nodes to wait at once while only one token comes back.

// File: rtl/stoppable_clk_en.sv
module stoppable_clk_en #(
  parameter int          NODES   = 4,
  parameter int          DIV_W   = 8,
  parameter int unsigned DIV_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NODES-1:0] node_req,
  input  logic [NODES-1:0] tok_arrive,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick,
  output logic             stopped
);

  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RST);

  logic [NODES-1:0] pend_q;
  logic [DIV_W-1:0] ratio_q, cnt_q;
  logic             halt_q;
  logic             all_ok;

  assign all_ok  = &(node_req | pend_q | tok_arrive);
  assign stopped = halt_q | ~all_ok;
  assign tick    = ~stopped & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      ratio_q <= DIV_INIT;
      cnt_q   <= DIV_INIT;
      halt_q  <= 1'b1;
    end else begin
      pend_q <= (pend_q | tok_arrive) & ~node_req;
      halt_q <= ~all_ok;
      if (div_wr && stopped) ratio_q <= div_val;
      if (stopped || tick) cnt_q <= ratio_q;
      else                 cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r10_no_tick_while_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !tick);

  a_r3_unsatisfied_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~node_req & ~pend_q & ~tok_arrive)) |-> (stopped && !tick));

  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio_q != '0) |=> !tick);

  a_r6_restart_full_period: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(halt_q) && ratio_q != '0) |-> !tick);

  a_r7_ratio_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !stopped |=> $stable(ratio_q));

  a_r5_release_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_arrive[0] && !node_req[0]) |=> (pend_q[0] || node_req[0]));

endmodule

// File: tb/tb_stoppable_clk_en.sv
module tb_stoppable_clk_en;
  localparam int NODES = 3;
  localparam int DIV_W = 4;
  localparam int DRST  = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NODES-1:0] node_req = '1;
  logic [NODES-1:0] tok_arrive = '0;
  logic             div_wr = 1'b0;
  logic [DIV_W-1:0] div_val = '0;
  logic             tick, stopped;

  stoppable_clk_en #(.NODES(NODES), .DIV_W(DIV_W), .DIV_RST(DRST)) dut (
    .clk(clk), .rst_n(rst_n), .node_req(node_req), .tok_arrive(tok_arrive),
    .div_wr(div_wr), .div_val(div_val), .tick(tick), .stopped(stopped));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int m_div, m_tgt, m_phase;
  bit m_stop;
  bit [NODES-1:0] m_pend;
  string tag = "R9";
  int cyc_n = 0, last_tick = -1, gap = -1;

  task automatic chk(input string r, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", r, cyc_n, act, exp);
    end
  endtask

  task automatic cyc();
    bit ok = 1'b1;
    bit e_st, e_tk;
    #1;
    for (int i = 0; i < NODES; i++)
      if (!(node_req[i] || m_pend[i] || tok_arrive[i])) ok = 1'b0;
    e_st = m_stop || !ok;
    e_tk = !e_st && (m_phase == m_tgt);
    chk({tag, " tick"}, int'(tick), int'(e_tk));
    chk({tag, " stopped"}, int'(stopped), int'(e_st));
    if (tick) begin
      if (last_tick >= 0) gap = cyc_n - last_tick;
      last_tick = cyc_n;
    end
    @(posedge clk);
    if (e_st || e_tk) begin m_tgt = m_div; m_phase = 0; end
    else m_phase++;
    m_pend = (m_pend | tok_arrive) & ~node_req;
    if (div_wr && e_st) m_div = int'(div_val);
    m_stop = !ok;
    cyc_n++;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit [15:0] lf;
    repeat (3) @(negedge clk);
    chk("R9 reset tick", int'(tick), 0);
    chk("R9 reset stopped", int'(stopped), 1);
    m_div = DRST; m_tgt = DRST; m_phase = 0; m_stop = 1'b1; m_pend = '0;
    rst_n = 1'b1;
    tag = "R9"; run(2);
    tag = "R1"; run(20);
    chk("R1 spacing", gap, DRST + 1);

    // write while running: ignored
    tag = "R7"; div_wr = 1'b1; div_val = 4'd9; cyc(); div_wr = 1'b0;
    run(12);
    chk("R7 spacing unchanged", gap, DRST + 1);

    // one late node, others keep requesting
    tag = "R4"; node_req[1] = 1'b0; run(6);
    tag = "R8"; div_wr = 1'b1; div_val = 4'd5; cyc(); div_wr = 1'b0; run(2);
    tag = "R5"; tok_arrive[1] = 1'b1; cyc(); tok_arrive[1] = 1'b0;
    tag = "R6"; run(4); node_req[1] = 1'b1; run(20);
    chk("R8 new spacing", gap, 6);

    // early token on a requesting node has no effect
    tag = "R5"; tok_arrive[2] = 1'b1; cyc(); tok_arrive[2] = 1'b0; run(3);
    node_req[2] = 1'b0; run(5);
    chk("R5 early token ignored", int'(stopped), 1);

    // two waiting nodes, one token
    tag = "R4"; node_req[0] = 1'b0; run(3);
    tok_arrive[0] = 1'b1; cyc(); tok_arrive[0] = 1'b0; run(4);
    chk("R4 still stopped", int'(stopped), 1);
    tag = "R3"; div_wr = 1'b1; div_val = 4'd0; cyc(); div_wr = 1'b0;
    tok_arrive[2] = 1'b1; cyc(); tok_arrive[2] = 1'b0;
    tag = "R6"; run(3); node_req = '1; run(8);
    chk("R1 divide by one", gap, 1);

    tag = "R2"; node_req[2] = 1'b0; run(3); div_wr = 1'b1; div_val = 4'd15; cyc();
    div_wr = 1'b0; tok_arrive[2] = 1'b1; cyc(); tok_arrive[2] = 1'b0;
    node_req[2] = 1'b1; tag = "R10"; run(40);
    chk("R1 largest ratio", gap, 16);

    // pseudo-random traffic
    lf = 16'hACE1;
    tag = "R3";
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < NODES; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[3:0] == 4'h0) node_req[i] = ~node_req[i];
        tok_arrive[i] = (lf[7:5] == 3'b000);
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      div_wr = (lf[3:0] == 4'h5);
      div_val = lf[11:8];
      cyc();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule